// File: doc/BRIEF.md
# Line Pixel Uniformity Statistics Unit

This unit measures how uniform one color channel of a linear image sensor is. Digitised pixel samples arrive as a stream. A flag on each sample tells real image cells apart from dummy, shielded and spare cells, and a second flag marks the odd pixel of each odd/even pair. Once a full line of real pixels has been captured, the unit reports five results. The first is the integer line average. The second is the largest absolute distance of any pixel from that average, in raw sample units; under shielded conditions this is the dark non-uniformity figure. The third is that distance as a percentage of the average. The fourth is the odd/even register imbalance as a percentage. The fifth is an error flag that is set when the average is zero.

The first pass adds up the line and stores every real pixel in an internal buffer. The second pass reads the buffer back and finds the largest deviation from the average. All quotients come from one shared sequential divider. The unit can also follow one selected pixel position over a programmed number of lines. From its sum and sum of squares it gives a mean and a population variance, for noise measurement.

The input follows valid/ready rules. A sample transfers on a rising clock edge where `in_valid` and `in_ready` are both high. The source must hold the sample steady while `in_ready` is low. `in_ready` falls after the last real pixel of a line and rises again only in the cycle where results are published. Results stay in output registers until the next line is published.

Top module: `line_uniformity_stats`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `in_ready` is 1. `res_done` and `noise_done` are 0, and every result output is 0.
- R2: `in_ready` is 0 from the cycle after the NPIX-th real pixel has been accepted. It returns to 1 exactly in the cycle where `res_done` is 1.
- R3: Samples accepted with `in_active` = 0 change no result, whatever their data or odd flag.
- R4: `res_mean` equals floor(S / NPIX), where S is the sum of the NPIX real pixels of the line.
- R5: `res_maxdev` equals the maximum over the line of |x - `res_mean`|, in raw units. This holds even when the error flag is set.
- R6: When the mean is non-zero, `res_nonunif` equals floor(`res_maxdev` * 10000 / `res_mean`). This is a percentage with two decimal places, so 5000 means 50.00 %.
- R7: The imbalance sum D adds |a - b| for each real pixel a flagged odd (`in_odd` = 1) and the next real pixel b flagged even. When the mean is non-zero, `res_imbal` equals floor(20000 * D / S), in the same hundredths-of-percent scale. An even-flagged pixel that has no odd partner waiting adds nothing.
- R8: `res_err` is 1 exactly when `res_mean` is 0. In that case `res_nonunif` and `res_imbal` read 0.
- R9: With `cfg_noise_en` = 1, the pixel at real-pixel index `cfg_noise_idx` (0-based) is accumulated each line. On every L-th line (L = `cfg_noise_lines`, at least 1), `noise_done` pulses together with `res_done`. At that point `noise_mean` = floor(Σx / L) and `noise_var` = floor((L*Σx² - (Σx)²) / L²), and accumulation starts again. On other lines `noise_done` stays 0. Dropping `cfg_noise_en` clears the line count.
- R10: `res_done` is a one-cycle pulse. All result outputs hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Unit can take a sample |
| in_data | input | SAMPLE_W | Pixel level |
| in_active | input | 1 | Sample is a real image cell |
| in_odd | input | 1 | Sample is the odd pixel of a pair |
| cfg_noise_en | input | 1 | Enable single-pixel noise accumulation |
| cfg_noise_idx | input | clog2(NPIX) | Real-pixel index to follow |
| cfg_noise_lines | input | clog2(NLINES_MAX+1) | Lines per noise result |
| res_done | output | 1 | Line results published (pulse) |
| res_err | output | 1 | Line mean was zero |
| res_mean | output | SAMPLE_W | Line average |
| res_maxdev | output | SAMPLE_W | Largest deviation from the average |
| res_nonunif | output | SAMPLE_W+14 | Non-uniformity, hundredths of percent |
| res_imbal | output | SAMPLE_W+14 | Odd/even imbalance, hundredths of percent |
| noise_done | output | 1 | Noise results published (pulse) |
| noise_mean | output | SAMPLE_W | Mean of the followed pixel |
| noise_var | output | 2*SAMPLE_W | Variance of the followed pixel |

## Verification
If the buffer address or the average is wrong, the fault shows up in `res_maxdev` and `res_nonunif` of the same line, within one line time after the last pixel. If the odd/even pairing latch or the inactive-sample gating is wrong, the fault appears in `res_mean` or `res_imbal` of the line where it happens. Faults confined to the inserted filler cells are only visible when those filler cells carry extreme data. A wrong noise line count appears as a missing or misplaced `noise_done` pulse, so it can take up to L lines to notice. A stuck control state shows up at once: `in_ready` never returns.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

  typedef enum logic [3:0] {
    ST_CAP,    // first pass: take pixels, sum, pair, buffer
    ST_MEAN,   // line sum / NPIX
    ST_SCAN,   // second pass: read buffer, largest deviation
    ST_NU,     // deviation percentage
    ST_IMB,    // imbalance percentage
    ST_NOISE,  // decide whether noise figures are due
    ST_NMEAN,  // noise sum / L
    ST_NVAR,   // noise variance
    ST_DONE    // publish
  } lpu_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpu_divider.sv
module lpu_divider #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem;
  logic [W-1:0]  dvd;
  logic [W-1:0]  den_q;
  logic [CW-1:0] left;
  logic          run;
  logic [W:0]    trial;
  logic          fits;

  // restoring division, one quotient bit per cycle
  assign trial = {rem, dvd[W-1]};
  assign fits  = (trial >= {1'b0, den_q});
  assign quot  = dvd;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      done  <= 1'b0;
      rem   <= '0;
      dvd   <= '0;
      den_q <= '0;
      left  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run   <= 1'b1;
        rem   <= '0;
        dvd   <= num;
        den_q <= den;
        left  <= CW'(W);
      end else if (run) begin
        rem  <= fits ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
        dvd  <= {dvd[W-2:0], fits};
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lpu_linebuf.sv
module lpu_linebuf #(
  parameter int W     = 12,
  parameter int DEPTH = 3750,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/lpu_accum.sv
module lpu_accum #(
  parameter int SW    = 12,
  parameter int SUM_W = 24,
  parameter int NS_W  = 19,
  parameter int NSQ_W = 31,
  parameter int IW    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_clr,
  input  logic             noise_clr,
  input  logic             take,
  input  logic [SW-1:0]    data,
  input  logic             odd,
  input  logic [IW-1:0]    idx,
  input  logic             sel_en,
  input  logic [IW-1:0]    sel_idx,
  output logic [SUM_W-1:0] sum,
  output logic [SUM_W-1:0] diffsum,
  output logic [NS_W-1:0]  nsum,
  output logic [NSQ_W-1:0] nsq
);
  logic [SW-1:0] pend;
  logic          pend_v;
  logic [SW-1:0] gap;

  assign gap = (pend >= data) ? (pend - data) : (data - pend);

  // line sum and odd/even pairing
  always_ff @(posedge clk) begin
    if (rst || line_clr) begin
      sum     <= '0;
      diffsum <= '0;
      pend    <= '0;
      pend_v  <= 1'b0;
    end else if (take) begin
      sum <= sum + SUM_W'(data);
      if (odd) begin
        pend   <= data;
        pend_v <= 1'b1;
      end else if (pend_v) begin
        diffsum <= diffsum + SUM_W'(gap);
        pend_v  <= 1'b0;
      end
    end
  end

  // single-pixel sum and sum of squares across lines
  always_ff @(posedge clk) begin
    if (rst || noise_clr) begin
      nsum <= '0;
      nsq  <= '0;
    end else if (take && sel_en && (idx == sel_idx)) begin
      nsum <= nsum + NS_W'(data);
      nsq  <= nsq + NSQ_W'(data) * NSQ_W'(data);
    end
  end
endmodule

// File: rtl/line_uniformity_stats.sv
module line_uniformity_stats
  import lpu_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int NPIX       = 3750,
  parameter int NLINES_MAX = 100
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [SAMPLE_W-1:0]               in_data,
  input  logic                              in_active,
  input  logic                              in_odd,
  input  logic                              cfg_noise_en,
  input  logic [$clog2(NPIX)-1:0]           cfg_noise_idx,
  input  logic [$clog2(NLINES_MAX+1)-1:0]   cfg_noise_lines,
  output logic                              res_done,
  output logic                              res_err,
  output logic [SAMPLE_W-1:0]               res_mean,
  output logic [SAMPLE_W-1:0]               res_maxdev,
  output logic [SAMPLE_W+13:0]              res_nonunif,
  output logic [SAMPLE_W+13:0]              res_imbal,
  output logic                              noise_done,
  output logic [SAMPLE_W-1:0]               noise_mean,
  output logic [2*SAMPLE_W-1:0]             noise_var
);
  localparam int SW    = SAMPLE_W;
  localparam int IW    = $clog2(NPIX);
  localparam int LW    = $clog2(NLINES_MAX + 1);
  localparam int SUM_W = SW + $clog2(NPIX + 1);
  localparam int NS_W  = SW + LW;
  localparam int NSQ_W = 2 * SW + LW;
  localparam int PCT_W = SW + 14;
  localparam int DW    = imax(2 * NS_W + 1, SUM_W + 16);
  localparam int QU_W  = imax(PCT_W, 2 * SW);

  lpu_state_e state;

  logic [IW-1:0]    cnt;
  logic [IW-1:0]    rp;
  logic             iss, rvld, rlast;
  logic [LW-1:0]    nlines;
  logic             nfire;
  logic [SW-1:0]    mean_q, maxdev_q, nm_q;
  logic [PCT_W-1:0] nu_q, imb_q;
  logic [2*SW-1:0]  nv_q;
  logic             err_q;

  logic             div_go, div_done;
  logic [DW-1:0]    div_num, div_den, div_q;
  logic             unused_q_hi;

  logic             take;
  logic [SW-1:0]    rd_data, dev, dev_max;
  logic [SUM_W-1:0] sum, diffsum;
  logic [NS_W-1:0]  nsum;
  logic [NSQ_W-1:0] nsq;
  logic             line_clr, noise_clr;

  assign in_ready    = (state == ST_CAP);
  assign take        = in_valid && in_ready && in_active;
  assign line_clr    = (state == ST_DONE);
  assign noise_clr   = !cfg_noise_en || (line_clr && nfire);
  assign dev         = (rd_data >= mean_q) ? (rd_data - mean_q) : (mean_q - rd_data);
  assign dev_max     = (dev > maxdev_q) ? dev : maxdev_q;
  assign unused_q_hi = ^div_q[DW-1:QU_W];

  lpu_accum #(
    .SW(SW), .SUM_W(SUM_W), .NS_W(NS_W), .NSQ_W(NSQ_W), .IW(IW)
  ) u_acc (
    .clk(clk), .rst(rst), .line_clr(line_clr), .noise_clr(noise_clr),
    .take(take), .data(in_data), .odd(in_odd), .idx(cnt),
    .sel_en(cfg_noise_en), .sel_idx(cfg_noise_idx),
    .sum(sum), .diffsum(diffsum), .nsum(nsum), .nsq(nsq)
  );

  lpu_linebuf #(.W(SW), .DEPTH(NPIX), .AW(IW)) u_buf (
    .clk(clk),
    .wr_en(take), .wr_addr(cnt), .wr_data(in_data),
    .rd_en((state == ST_SCAN) && iss), .rd_addr(rp), .rd_data(rd_data)
  );

  lpu_divider #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .start(div_go),
    .num(div_num), .den(div_den), .done(div_done), .quot(div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_CAP;
      cnt         <= '0;
      rp          <= '0;
      iss         <= 1'b0;
      rvld        <= 1'b0;
      rlast       <= 1'b0;
      nlines      <= '0;
      nfire       <= 1'b0;
      mean_q      <= '0;
      maxdev_q    <= '0;
      nm_q        <= '0;
      nu_q        <= '0;
      imb_q       <= '0;
      nv_q        <= '0;
      err_q       <= 1'b0;
      div_go      <= 1'b0;
      div_num     <= '0;
      div_den     <= '0;
      res_done    <= 1'b0;
      res_err     <= 1'b0;
      res_mean    <= '0;
      res_maxdev  <= '0;
      res_nonunif <= '0;
      res_imbal   <= '0;
      noise_done  <= 1'b0;
      noise_mean  <= '0;
      noise_var   <= '0;
    end else begin
      div_go     <= 1'b0;
      res_done   <= 1'b0;
      noise_done <= 1'b0;
      rvld       <= (state == ST_SCAN) && iss;
      rlast      <= (state == ST_SCAN) && iss && (rp == IW'(NPIX - 1));
      unique case (state)
        ST_CAP: begin
          if (take) begin
            if (cnt == IW'(NPIX - 1)) begin
              cnt     <= '0;
              nfire   <= cfg_noise_en && ((nlines + LW'(1)) == cfg_noise_lines);
              div_go  <= 1'b1;
              div_num <= DW'(sum) + DW'(in_data);
              div_den <= DW'(NPIX);
              state   <= ST_MEAN;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_MEAN: begin
          if (div_done) begin
            mean_q   <= div_q[SW-1:0];
            err_q    <= (div_q[SW-1:0] == '0);
            maxdev_q <= '0;
            rp       <= '0;
            iss      <= 1'b1;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (iss) begin
            rp <= rp + 1'b1;
            if (rp == IW'(NPIX - 1)) iss <= 1'b0;
          end
          if (rvld) begin
            maxdev_q <= dev_max;
            if (rlast) begin
              if (err_q) begin
                nu_q  <= '0;
                imb_q <= '0;
                state <= ST_NOISE;
              end else begin
                div_go  <= 1'b1;
                div_num <= DW'(dev_max) * DW'(14'd10000);
                div_den <= DW'(mean_q);
                state   <= ST_NU;
              end
            end
          end
        end
        ST_NU: begin
          if (div_done) begin
            nu_q    <= div_q[PCT_W-1:0];
            div_go  <= 1'b1;
            div_num <= DW'(diffsum) * DW'(15'd20000);
            div_den <= DW'(sum);
            state   <= ST_IMB;
          end
        end
        ST_IMB: begin
          if (div_done) begin
            imb_q <= div_q[PCT_W-1:0];
            state <= ST_NOISE;
          end
        end
        ST_NOISE: begin
          if (nfire) begin
            div_go  <= 1'b1;
            div_num <= DW'(nsum);
            div_den <= DW'(cfg_noise_lines);
            state   <= ST_NMEAN;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_NMEAN: begin
          if (div_done) begin
            nm_q    <= div_q[SW-1:0];
            div_go  <= 1'b1;
            div_num <= DW'(cfg_noise_lines) * DW'(nsq) - DW'(nsum) * DW'(nsum);
            div_den <= DW'(cfg_noise_lines) * DW'(cfg_noise_lines);
            state   <= ST_NVAR;
          end
        end
        ST_NVAR: begin
          if (div_done) begin
            nv_q  <= div_q[2*SW-1:0];
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          res_done    <= 1'b1;
          res_err     <= err_q;
          res_mean    <= mean_q;
          res_maxdev  <= maxdev_q;
          res_nonunif <= nu_q;
          res_imbal   <= imb_q;
          if (nfire) begin
            noise_done <= 1'b1;
            noise_mean <= nm_q;
            noise_var  <= nv_q;
            nlines     <= '0;
          end else if (cfg_noise_en) begin
            nlines <= nlines + 1'b1;
          end
          state <= ST_CAP;
        end
        default: state <= ST_CAP;
      endcase
      if (!cfg_noise_en) nlines <= '0;
    end
  end
endmodule

// File: rtl/lpu_checker.sv
module lpu_checker #(
  parameter int SW = 12,
  parameter int PW = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          res_done,
  input logic          res_err,
  input logic [SW-1:0] res_mean,
  input logic [SW-1:0] res_maxdev,
  input logic [PW-1:0] res_nonunif,
  input logic [PW-1:0] res_imbal,
  input logic          noise_done
);
  p_reset_exit_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !res_done && !noise_done));

  p_ready_returns_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> res_done);

  p_done_ready_r2: assert property (@(posedge clk) disable iff (rst)
    res_done |-> in_ready);

  p_imbal_bound_r7: assert property (@(posedge clk) disable iff (rst)
    res_done |-> (res_imbal <= PW'(20000)));

  p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (res_done && res_err) |-> (res_mean == '0 && res_nonunif == '0 && res_imbal == '0));

  p_mean_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    (res_done && !res_err) |-> (res_mean != '0));

  p_noise_with_line_r9: assert property (@(posedge clk) disable iff (rst)
    noise_done |-> res_done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    res_done |=> !res_done);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !res_done |-> ($stable(res_mean) && $stable(res_maxdev) &&
                   $stable(res_nonunif) && $stable(res_imbal) && $stable(res_err)));
endmodule

bind line_uniformity_stats lpu_checker #(.SW(SAMPLE_W), .PW(PCT_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .res_done(res_done),
  .res_err(res_err), .res_mean(res_mean), .res_maxdev(res_maxdev),
  .res_nonunif(res_nonunif), .res_imbal(res_imbal), .noise_done(noise_done)
);

// File: tb/sim_line_uniformity_stats.sv
`timescale 1ns/1ps
module sim_line_uniformity_stats;
  localparam int SW  = 8;
  localparam int NP  = 8;
  localparam int NLM = 7;
  localparam int IW  = 3;
  localparam int LW  = 3;
  localparam int PW  = SW + 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_active = 1'b0, in_odd = 1'b0;
  logic [SW-1:0] in_data = '0;
  logic in_ready;
  logic cfg_noise_en = 1'b0;
  logic [IW-1:0] cfg_noise_idx = '0;
  logic [LW-1:0] cfg_noise_lines = 3'd1;
  logic res_done, res_err, noise_done;
  logic [SW-1:0] res_mean, res_maxdev, noise_mean;
  logic [PW-1:0] res_nonunif, res_imbal;
  logic [2*SW-1:0] noise_var;

  int checks = 0;
  int errors = 0;
  int unsigned seed = 32'h1234_5678;
  int pix [NP];

  longint e_mean, e_maxdev, e_nu, e_imb, e_err;
  longint n_s, n_q, n_lines;

  always #10 clk = ~clk;

  line_uniformity_stats #(.SAMPLE_W(SW), .NPIX(NP), .NLINES_MAX(NLM)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_active(in_active), .in_odd(in_odd),
    .cfg_noise_en(cfg_noise_en), .cfg_noise_idx(cfg_noise_idx),
    .cfg_noise_lines(cfg_noise_lines), .res_done(res_done), .res_err(res_err),
    .res_mean(res_mean), .res_maxdev(res_maxdev), .res_nonunif(res_nonunif),
    .res_imbal(res_imbal), .noise_done(noise_done), .noise_mean(noise_mean),
    .noise_var(noise_var)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  task automatic expect_line();
    longint s, d, mx, dv;
    s = 0; d = 0; mx = 0;
    for (int k = 0; k < NP; k++) s += pix[k];
    e_mean = s / NP;
    for (int k = 0; k < NP; k++) begin
      dv = (pix[k] >= e_mean) ? pix[k] - e_mean : e_mean - pix[k];
      if (dv > mx) mx = dv;
    end
    for (int k = 0; k < NP; k += 2)
      d += (pix[k] >= pix[k+1]) ? pix[k] - pix[k+1] : pix[k+1] - pix[k];
    e_maxdev = mx;
    e_err    = (e_mean == 0) ? 1 : 0;
    e_nu     = e_err ? 0 : (mx * 10000) / e_mean;
    e_imb    = e_err ? 0 : (20000 * d) / s;
  endtask

  task automatic put(input int d, input logic act, input logic odd);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = SW'(d);
    in_active = act;
    in_odd    = odd;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // junk: 0 none, 1 filler cells with extreme data between pixels
  task automatic send_line(input int junk);
    for (int k = 0; k < NP; k++) begin
      if (junk != 0 && (k % 3 == 0)) begin
        put(255, 1'b0, 1'b1);
        put(rnd() & 255, 1'b0, 1'b0);
      end
      put(pix[k], 1'b1, (k % 2) == 0);
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_active = 1'b0;
    chk("R2 ready low after last pixel", in_ready, 0);
  endtask

  task automatic run_line(input string nm, input int junk);
    logic [SW-1:0] held;
    longint l_cfg;
    expect_line();
    l_cfg = cfg_noise_lines;
    if (cfg_noise_en) begin
      n_s += pix[cfg_noise_idx];
      n_q += pix[cfg_noise_idx] * pix[cfg_noise_idx];
      n_lines++;
    end
    send_line(junk);
    while (!res_done) @(negedge clk);
    chk({"R2 ready with done ", nm}, in_ready, 1);
    chk({"R4 mean ", nm}, res_mean, e_mean);
    chk({"R5 maxdev ", nm}, res_maxdev, e_maxdev);
    chk({"R6 nonunif ", nm}, res_nonunif, e_nu);
    chk({"R7 imbal ", nm}, res_imbal, e_imb);
    chk({"R8 err ", nm}, res_err, e_err);
    if (cfg_noise_en && n_lines == l_cfg) begin
      chk({"R9 noise_done ", nm}, noise_done, 1);
      chk({"R9 noise_mean ", nm}, noise_mean, n_s / l_cfg);
      chk({"R9 noise_var ", nm}, noise_var, (l_cfg * n_q - n_s * n_s) / (l_cfg * l_cfg));
      n_s = 0; n_q = 0; n_lines = 0;
    end else begin
      chk({"R9 no noise_done ", nm}, noise_done, 0);
    end
    held = res_mean;
    @(negedge clk);
    chk({"R10 done is a pulse ", nm}, res_done, 0);
    chk({"R10 mean held ", nm}, res_mean, held);
  endtask

  task automatic noise_cfg(input logic en, input int idx, input int lines);
    @(negedge clk);
    cfg_noise_en = 1'b0;
    @(negedge clk);
    cfg_noise_idx   = IW'(idx);
    cfg_noise_lines = LW'(lines);
    cfg_noise_en    = en;
    n_s = 0; n_q = 0; n_lines = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    n_s = 0; n_q = 0; n_lines = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", in_ready, 1);
    chk("R1 done in reset", res_done, 0);
    chk("R1 noise_done in reset", noise_done, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 1);
    chk("R1 mean after reset", res_mean, 0);
    chk("R1 nonunif after reset", res_nonunif, 0);
    chk("R1 var after reset", noise_var, 0);

    for (int k = 0; k < NP; k++) pix[k] = 100;
    run_line("flat", 0);
    for (int k = 0; k < NP; k++) pix[k] = 0;
    run_line("zero", 0);
    for (int k = 0; k < NP; k++) pix[k] = (k % 2 == 0) ? 10 : 30;
    run_line("alternate", 0);
    run_line("R3 alternate with fillers", 1);
    for (int k = 0; k < NP; k++) pix[k] = (k == NP - 1) ? 7 : 0;
    run_line("dark spike", 1);
    for (int k = 0; k < NP; k++) pix[k] = 255;
    run_line("full scale", 1);
    for (int k = 0; k < NP; k++) pix[k] = (k == 0) ? 255 : 1;
    run_line("single bright", 0);

    noise_cfg(1'b1, 5, 4);
    for (int ln = 0; ln < 12; ln++) begin
      for (int k = 0; k < NP; k++) pix[k] = (ln % 5 == 4) ? (rnd() & 3) : (rnd() & 255);
      run_line("R9 noise run", ln % 2);
    end
    noise_cfg(1'b1, 0, 1);
    for (int ln = 0; ln < 3; ln++) begin
      for (int k = 0; k < NP; k++) pix[k] = 20 + (rnd() & 63);
      run_line("R9 one-line noise", 0);
    end
    noise_cfg(1'b1, 7, 7);
    for (int ln = 0; ln < 7; ln++) begin
      for (int k = 0; k < NP; k++) pix[k] = rnd() & 255;
      run_line("R9 seven-line noise", 1);
    end
    noise_cfg(1'b0, 0, 1);
    for (int ln = 0; ln < 20; ln++) begin
      for (int k = 0; k < NP; k++) pix[k] = (ln % 4 == 0) ? (rnd() & 7) : (rnd() & 255);
      run_line("R3 sweep", ln % 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule